// File: doc/BRIEF.md
# PCI Interrupt Router with Legacy-Mapping Detection

This block collects the four level-sensitive interrupt pins (INTA to INTD) of a group of PCI slots and folds them onto four system interrupt lines. Which line a given slot and pin reaches depends on a rotation by slot number. The rotation constant depends on which board variant is selected. Each system line is the OR of every request that is currently routed to it.

Older system software expects a plain mapping, where pin N drives line N whatever the slot. To support it, the block watches configuration writes to the interrupt-line register (byte offset 0x3C of a function's header). The first such write that tells the two mappings apart settles the mapping for good. The value 27 selects the plain legacy mapping. Any other value confirms the rotated one. After that the software may write the register freely. On the alternate board the detector is off and the rotated mapping with the alternate constant always applies.

A three-state machine holds the decision. It has three states: ASSUME (the reset state, rotated mapping), LEGACY (identity mapping) and FORCED (rotated mapping). There are two transitions, both out of ASSUME: ASSUME to LEGACY on a qualifying write of 27, and ASSUME to FORCED on a qualifying write of any other value. LEGACY and FORCED have no way out except reset. The state is encoded as ASSUME=0, LEGACY=1, FORCED=2. Slot index i of the request vector is bus slot FIRST_SLOT+i. Request bit i*4+p is pin p of that slot, with p=0 for INTA through p=3 for INTD.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, map_state reads 0 (ASSUME).
- R2: In ASSUME on the default board (alt_board=0), a write that meets all three conditions below moves map_state to 1 (LEGACY) at the next clock edge. The write has cfg_offset[7:0]=0x3C. Its slot number cfg_offset[15:11] modulo 4 is not 2. Its cfg_data is 27.
- R3: In ASSUME on the default board, a write that meets the same offset and slot conditions with any cfg_data other than 27 moves map_state to 2 (FORCED).
- R4: A write to offset 0x3C whose slot number modulo 4 equals 2 leaves map_state unchanged.
- R5: A write whose cfg_offset[7:0] is not 0x3C leaves map_state unchanged. The same holds for any cycle with cfg_wr=0, whatever the offset and data.
- R6: Once map_state is 1 or 2, no write changes it until reset.
- R7: With alt_board=1, no write changes map_state.
- R8: In LEGACY with alt_board=0, irq_out[N] is the OR of pin N over all slots.
- R9: In ASSUME or FORCED with alt_board=0, request (slot s, pin p) drives irq_out[(s+p+2) mod 4]. For example, slot 31 INTA drives line 1 and slot 29 INTA drives line 3.
- R10: With alt_board=1, request (slot s, pin p) drives irq_out[(s+p+3) mod 4] in every state. For example, slot 31 INTA drives line 2 and slot 30 INTA drives line 1.
- R11: Each irq_out line is the OR of all requests mapped to it. It follows irq_req combinationally, and it follows a new map_state right after the edge that stores it.
- R12: cfg_offset[23:16] has no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one per cycle |
| cfg_offset | input | 24 | Configuration offset: [15:8] device/function, [7:0] register |
| cfg_data | input | 8 | Write data byte |
| alt_board | input | 1 | 0 = default board, 1 = alternate board |
| irq_req | input | 4*NUM_SLOTS | Level requests, bit i*4+p = slot FIRST_SLOT+i, pin p |
| irq_out | output | 4 | System interrupt lines |
| map_state | output | 2 | 0 ASSUME, 1 LEGACY, 2 FORCED |

## Verification
The bench goes after the following corner cases, each with a known symptom when the design gets it wrong:

- The slot-modulo-2 exclusion: a design that skips it would settle on writes from the slot where both mappings agree.
- The data value 27 exactly: an off-by-one comparison would pick FORCED instead of LEGACY.
- Stickiness: a design that lets a later write re-decide would flip routing under new software.
- The alternate board: a design that still detects there would leave ASSUME, or would switch to identity routing.
- Offset-byte neighbours such as 0x3D, and the ignored bus bits [23:16]: a design that decodes these wrongly would mis-trigger.
- Routing in every state under random request patterns: a wrong rotation constant or a missing OR shows up as a wrong line.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

    typedef enum logic [1:0] {
        MAP_ASSUME = 2'd0,
        MAP_LEGACY = 2'd1,
        MAP_FORCED = 2'd2
    } map_state_t;

    typedef enum logic [1:0] {
        ROUTE_MAIN  = 2'd0,
        ROUTE_ALT   = 2'd1,
        ROUTE_IDENT = 2'd2
    } route_mode_t;

    localparam int          PINS_PER_SLOT  = 4;
    localparam int          NUM_LINES      = 4;
    localparam logic [7:0]  INTLINE_REG    = 8'h3C;
    localparam logic [7:0]  LEGACY_LINE    = 8'd27;
    localparam int          ROT_MAIN       = 2;
    localparam int          ROT_ALT        = 3;
    localparam logic [1:0]  NEUTRAL_SLOT   = 2'd2;

    function automatic int line_of(input int slot, input int pin, input int rot);
        return (slot + pin + rot) % NUM_LINES;
    endfunction

endpackage

// File: rtl/pci_cfg_snoop.sv
module pci_cfg_snoop
    import pci_irq_router_pkg::*;
#(
    parameter int OFS_W = 24
) (
    input  logic             cfg_wr,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic [7:0]       cfg_data,
    output logic             qual_hit,
    output logic             legacy_val
);
    localparam int DEVFN_LO = 8;
    localparam int SLOT_LO  = DEVFN_LO + 3;

    logic [7:0] reg_byte;
    logic [4:0] slot_num;
    logic       unused_hi_bits;

    assign reg_byte       = cfg_offset[DEVFN_LO-1:0];
    assign slot_num       = cfg_offset[SLOT_LO+4:SLOT_LO];
    assign unused_hi_bits = ^{cfg_offset[OFS_W-1:SLOT_LO+5], cfg_offset[SLOT_LO-1:DEVFN_LO]};

    always_comb begin
        qual_hit   = cfg_wr && (reg_byte == INTLINE_REG) && (slot_num[1:0] != NEUTRAL_SLOT);
        legacy_val = (cfg_data == LEGACY_LINE);
    end

endmodule

// File: rtl/pci_map_fsm.sv
module pci_map_fsm
    import pci_irq_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alt_board,
    input  logic        qual_hit,
    input  logic        legacy_val,
    output map_state_t  state,
    output route_mode_t route_mode
);
    map_state_t state_q;
    map_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MAP_ASSUME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_ASSUME: begin
                if (qual_hit && !alt_board) begin
                    state_d = legacy_val ? MAP_LEGACY : MAP_FORCED;
                end
            end
            MAP_LEGACY: state_d = MAP_LEGACY;
            MAP_FORCED: state_d = MAP_FORCED;
            default:    state_d = MAP_ASSUME;
        endcase
    end

    always_comb begin
        route_mode = ROUTE_MAIN;
        if (alt_board) begin
            route_mode = ROUTE_ALT;
        end else begin
            unique case (state_q)
                MAP_LEGACY: route_mode = ROUTE_IDENT;
                MAP_ASSUME,
                MAP_FORCED: route_mode = ROUTE_MAIN;
                default:    route_mode = ROUTE_MAIN;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/pci_irq_mux.sv
module pci_irq_mux
    import pci_irq_router_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int FIRST_SLOT = 28
) (
    input  route_mode_t                        route_mode,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] irq_req,
    output logic [NUM_LINES-1:0]               irq_out
);
    localparam int REQ_W = NUM_SLOTS * PINS_PER_SLOT;

    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
        logic [REQ_W-1:0] mask_main;
        logic [REQ_W-1:0] mask_alt;
        logic [REQ_W-1:0] mask_ident;

        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            for (genvar p = 0; p < PINS_PER_SLOT; p++) begin : g_pin
                assign mask_main[s*PINS_PER_SLOT+p]  = (line_of(FIRST_SLOT + s, p, ROT_MAIN) == ln);
                assign mask_alt[s*PINS_PER_SLOT+p]   = (line_of(FIRST_SLOT + s, p, ROT_ALT) == ln);
                assign mask_ident[s*PINS_PER_SLOT+p] = (p == ln);
            end
        end

        always_comb begin
            unique case (route_mode)
                ROUTE_MAIN:  irq_out[ln] = |(irq_req & mask_main);
                ROUTE_ALT:   irq_out[ln] = |(irq_req & mask_alt);
                ROUTE_IDENT: irq_out[ln] = |(irq_req & mask_ident);
                default:     irq_out[ln] = |(irq_req & mask_main);
            endcase
        end
    end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pci_irq_router_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int FIRST_SLOT = 28,
    parameter int OFS_W      = 24
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_wr,
    input  logic [OFS_W-1:0]                   cfg_offset,
    input  logic [7:0]                         cfg_data,
    input  logic                               alt_board,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] irq_req,
    output logic [NUM_LINES-1:0]               irq_out,
    output logic [1:0]                         map_state
);
    logic        qual_hit;
    logic        legacy_val;
    map_state_t  state;
    route_mode_t route_mode;

    pci_cfg_snoop #(.OFS_W(OFS_W)) u_snoop (
        .cfg_wr     (cfg_wr),
        .cfg_offset (cfg_offset),
        .cfg_data   (cfg_data),
        .qual_hit   (qual_hit),
        .legacy_val (legacy_val)
    );

    pci_map_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .alt_board  (alt_board),
        .qual_hit   (qual_hit),
        .legacy_val (legacy_val),
        .state      (state),
        .route_mode (route_mode)
    );

    pci_irq_mux #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_mux (
        .route_mode (route_mode),
        .irq_req    (irq_req),
        .irq_out    (irq_out)
    );

    assign map_state = state;

endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
    parameter int NUM_SLOTS  = 4,
    parameter int FIRST_SLOT = 28,
    parameter int OFS_W      = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_wr,
    input logic [OFS_W-1:0]       cfg_offset,
    input logic [7:0]             cfg_data,
    input logic                   alt_board,
    input logic [NUM_SLOTS*4-1:0] irq_req,
    input logic [3:0]             irq_out,
    input logic [1:0]             map_state
);
    logic       lnk_write;
    logic       unused_chk;
    logic [3:0] exp_ident;

    assign lnk_write  = cfg_wr && (cfg_offset[7:0] == 8'h3C) && (cfg_offset[12:11] != 2'd2);
    assign unused_chk = ^{cfg_offset[OFS_W-1:13], cfg_offset[10:8], FIRST_SLOT[0]};

    always_comb begin
        exp_ident = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < 4; p++) begin
                if (irq_req[s*4+p]) exp_ident[p] = 1'b1;
            end
        end
    end

    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        map_state != 2'd3);

    p_to_legacy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (map_state == 2'd0 && !alt_board && lnk_write && cfg_data == 8'd27) |=> map_state == 2'd1);

    p_to_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_state == 2'd0 && !alt_board && lnk_write && cfg_data != 8'd27) |=> map_state == 2'd2);

    p_neutral_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_state == 2'd0 && !lnk_write) |=> map_state == 2'd0);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (map_state != 2'd0) |=> $stable(map_state));

    p_alt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (map_state == 2'd0 && alt_board) |=> map_state == 2'd0);

    p_legacy_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (map_state == 2'd1 && !alt_board) |-> irq_out == exp_ident);

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0) |-> irq_out == 4'd0);

endmodule

bind pci_irq_router pci_irq_router_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .FIRST_SLOT (FIRST_SLOT),
    .OFS_W      (OFS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_offset (cfg_offset),
    .cfg_data   (cfg_data),
    .alt_board  (alt_board),
    .irq_req    (irq_req),
    .irq_out    (irq_out),
    .map_state  (map_state)
);

// File: tb/pci_irq_router_bench.sv
`timescale 1ns/1ps
module pci_irq_router_bench;
    localparam int NS = 4;
    localparam int FS = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [23:0]   cfg_offset = '0;
    logic [7:0]    cfg_data = '0;
    logic          alt_board = 1'b0;
    logic [NS*4-1:0] irq_req = '0;
    logic [3:0]    irq_out;
    logic [1:0]    map_state;

    int total = 0;
    int bad = 0;
    int model_state = 0;

    always #2 clk = ~clk;

    pci_irq_router #(.NUM_SLOTS(NS), .FIRST_SLOT(FS)) u_pci_irq_router (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_offset(cfg_offset),
        .cfg_data(cfg_data), .alt_board(alt_board), .irq_req(irq_req),
        .irq_out(irq_out), .map_state(map_state)
    );

    function automatic logic [3:0] exp_route(input logic [NS*4-1:0] req, input int st, input logic alt);
        logic [3:0] r = '0;
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 4; p++) begin
                if (req[s*4+p]) begin
                    if (alt)          r[(FS+s+p+3)%4] = 1'b1;
                    else if (st == 1) r[p] = 1'b1;
                    else              r[(FS+s+p+2)%4] = 1'b1;
                end
            end
        end
        return r;
    endfunction

    function automatic int next_model(input int st, input logic alt, input logic [23:0] ofs, input logic [7:0] d);
        if (st == 0 && !alt && ofs[7:0] == 8'h3C && ofs[12:11] != 2'd2)
            return (d == 8'd27) ? 1 : 2;
        return st;
    endfunction

    task automatic chk_state(input string req, input int exp);
        total++;
        if (int'(map_state) != exp) begin
            bad++;
            $display("FAIL %s map_state got=%0d exp=%0d", req, map_state, exp);
        end
    endtask

    task automatic chk_route(input string req, input logic [NS*4-1:0] r);
        logic [3:0] e;
        @(negedge clk);
        irq_req = r;
        #1;
        e = exp_route(r, model_state, alt_board);
        total++;
        if (irq_out !== e) begin
            bad++;
            $display("FAIL %s irq_out got=%b exp=%b req=%h", req, irq_out, e, r);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_state = 0;
    endtask

    task automatic cfg_write(input logic [23:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_offset = ofs;
        cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_state = next_model(model_state, alt_board, ofs, d);
    endtask

    function automatic logic [23:0] ofs_for(input int slot, input logic [7:0] reg_b);
        return {8'h00, slot[4:0], 3'b000, reg_b};
    endfunction

    initial begin
        process::self().srandom(32'd1234);
        do_reset();
        chk_state("R1", 0);

        chk_route("R9", 16'h1000);
        total++;
        if (irq_out !== 4'b0010) begin bad++; $display("FAIL R9 slot31 INTA got=%b exp=%b", irq_out, 4'b0010); end
        chk_route("R9", 16'h0010);
        total++;
        if (irq_out !== 4'b1000) begin bad++; $display("FAIL R9 slot29 INTA got=%b exp=%b", irq_out, 4'b1000); end
        for (int i = 0; i < 20; i++) chk_route("R11", 16'($urandom));

        alt_board = 1'b1;
        chk_route("R10", 16'h1000);
        total++;
        if (irq_out !== 4'b0100) begin bad++; $display("FAIL R10 slot31 INTA got=%b exp=%b", irq_out, 4'b0100); end
        chk_route("R10", 16'h0100);
        total++;
        if (irq_out !== 4'b0010) begin bad++; $display("FAIL R10 slot30 INTA got=%b exp=%b", irq_out, 4'b0010); end
        cfg_write(ofs_for(31, 8'h3C), 8'd27);
        chk_state("R7", 0);
        alt_board = 1'b0;

        cfg_write(ofs_for(30, 8'h3C), 8'd27);
        chk_state("R4", 0);
        cfg_write(ofs_for(26, 8'h3C), 8'd5);
        chk_state("R4", 0);
        cfg_write(ofs_for(31, 8'h3D), 8'd27);
        chk_state("R5", 0);
        cfg_write(ofs_for(31, 8'h3B), 8'd9);
        chk_state("R5", 0);
        @(negedge clk);
        cfg_offset = ofs_for(31, 8'h3C);
        cfg_data = 8'd27;
        @(negedge clk);
        chk_state("R5", 0);

        cfg_write(24'hAB0000 | ofs_for(31, 8'h3C), 8'd27);
        chk_state("R2", 1);
        chk_state("R12", 1);
        for (int i = 0; i < 12; i++) chk_route("R8", 16'($urandom));
        cfg_write(ofs_for(28, 8'h3C), 8'd5);
        chk_state("R6", 1);
        alt_board = 1'b1;
        chk_route("R10", 16'h1234);
        alt_board = 1'b0;

        do_reset();
        chk_state("R1", 0);
        cfg_write(ofs_for(28, 8'h3C), 8'd26);
        chk_state("R3", 2);
        for (int i = 0; i < 8; i++) chk_route("R9", 16'($urandom));
        cfg_write(ofs_for(31, 8'h3C), 8'd27);
        chk_state("R6", 2);

        do_reset();
        cfg_write(ofs_for(29, 8'h3C), 8'd28);
        chk_state("R3", 2);

        for (int i = 0; i < 400; i++) begin
            logic [23:0] o;
            logic [7:0]  d;
            if (i % 40 == 0) do_reset();
            alt_board = ($urandom_range(0, 7) == 0);
            o = 24'($urandom);
            if ($urandom_range(0, 9) < 7) o[7:0] = 8'h3C;
            d = ($urandom_range(0, 1) == 0) ? 8'd27 : 8'($urandom);
            cfg_write(o, d);
            chk_state("R6", model_state);
            chk_route("R11", 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule